// File: doc/BRIEF.md
# Interrupt Presenter Register Front-End

This block is the bus-facing register decoder for one per-thread interrupt presenter. A simple bus gives it an address, a write enable, a size bit (32-bit word or single byte), write data and a valid strobe. From the offset, the size and the direction the block works out which presenter operation is meant. It then raises a one-cycle command strobe towards a separate presenter core. The commands are poll, accept, set current priority, end-of-interrupt and set pending-request priority. The values the core returns come back to the bus as registered read data.

The block does not do priority arbitration or source selection. The core does that. The front-end only translates accesses, and some of those translations have side effects: a word read of the request register acknowledges the pending interrupt. The front-end also holds three general-purpose 32-bit link registers. Illegal accesses are flagged on a sticky error output that only a dedicated clear input resets.

Top module: `icpf_top`

## Requirements
- R1: After reset, read data is zero, the error flag is low, and all link registers read back as zero.
- R2: A word read at offset 0 pulses only the poll strobe. On the next cycle it returns the full 32-bit poll value, and the accept count of the core does not change.
- R3: A byte read with address bits [1:0] zero, at offset 0 or at offset 4, pulses only the poll strobe. It returns the most significant byte of the poll value (the current priority) in read data bits [7:0], with bits [31:8] zero.
- R4: A word read at offset 4 pulses the accept strobe for exactly one cycle. The next cycle returns the accepted 32-bit value presented by the core in the cycle of the access.
- R5: A byte write with address bits [1:0] zero at offset 4 pulses the set-priority strobe, and the command data carries write data bits [7:0] zero-extended. A word write at offset 4 pulses the end-of-interrupt strobe and carries all 32 write-data bits.
- R6: At offset 12, a byte-0 write pulses the set-pending strobe with write data bits [7:0], and a byte-0 read returns the core's pending priority in bits [7:0]. A word access at offset 12 is illegal.
- R7: Offsets 16, 20 and 24 are link registers 0, 1 and 2. They accept only word reads and writes. A byte access to them is illegal and leaves them unchanged.
- R8: A byte access with address bits [1:0] not zero is illegal at every offset.
- R9: An illegal access raises no strobe and changes no state. This covers unmapped offsets (including 8, 28 and 0xFFC), any write at offset 0, and the wrong size. An illegal read returns 0xFFFFFFFF, and any illegal access sets the error flag on the following cycle.
- R10: The error flag stays set until the clear input is high. When an illegal access and the clear input fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data; byte writes use bits [7:0] |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the access |
| err_flag | output | 1 | Sticky illegal-access flag |
| err_clr | input | 1 | Clears the error flag |
| cmd_poll | output | 1 | Poll command strobe |
| cmd_accept | output | 1 | Accept (acknowledge) command strobe |
| cmd_cppr | output | 1 | Set-current-priority strobe |
| cmd_eoi | output | 1 | End-of-interrupt strobe |
| cmd_mfrr | output | 1 | Set-pending-priority strobe |
| cmd_data | output | 32 | Data carried with the write commands |
| core_poll | input | 32 | Current poll value from the core |
| core_accept | input | 32 | Value the core returns on accept |
| core_mfrr | input | 8 | Current pending-request priority from the core |

## Verification
The functions most likely to collide are setting the sticky error flag and clearing it, since the illegal access and the clear come from independent sources. The bench makes both happen in one cycle: it drives an unmapped read while err_clr is high. After that edge it expects the flag set, and it also expects a lone clear to drop the flag. A second overlap is the accept side effect against the registered read. The stub core advances its count at the same edge that latches the read data, and the bench expects the pre-advance value on the bus and the advanced value on the next accept.

// File: rtl/icpf_pkg.sv
package icpf_pkg;

   // decoded operation for one bus access
   typedef enum logic [3:0] {
      OP_NONE,
      OP_POLL_W,
      OP_POLL_B,
      OP_ACCEPT,
      OP_CPPR,
      OP_EOI,
      OP_PEND_RD,
      OP_PEND_WR,
      OP_LINK_RD,
      OP_LINK_WR,
      OP_BAD
   } op_e;

   // word indices (address bits above the byte lane) of the fixed registers
   localparam int IDX_POLL = 0;
   localparam int IDX_REQ  = 1;
   localparam int IDX_PEND = 3;

endpackage

// File: rtl/icpf_decode.sv
module icpf_decode
   import icpf_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_LINKS = 3,
   parameter int LINK_BASE = 4,
   localparam int IDX_W  = ADDR_W - 2,
   localparam int LSEL_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
   input  logic              acc_write,
   input  logic              acc_word,
   input  logic [ADDR_W-1:0] acc_addr,
   output op_e               acc_op,
   output logic [LSEL_W-1:0] link_sel
);

   logic [IDX_W-1:0] idx;
   logic             byte0;
   logic             link_hit;

   assign idx   = acc_addr[ADDR_W-1:2];
   assign byte0 = !acc_word && (acc_addr[1:0] == 2'b00);

   always_comb begin
      link_hit = 1'b0;
      link_sel = '0;
      for (int i = 0; i < NUM_LINKS; i++) begin
         if (idx == IDX_W'(LINK_BASE + i)) begin
            link_hit = 1'b1;
            link_sel = LSEL_W'(i);
         end
      end
   end

   always_comb begin
      acc_op = OP_BAD;
      if (idx == IDX_W'(IDX_POLL)) begin
         if (!acc_write) begin
            if (byte0)         acc_op = OP_POLL_B;
            else if (acc_word) acc_op = OP_POLL_W;
         end
      end else if (idx == IDX_W'(IDX_REQ)) begin
         if (acc_write) begin
            if (byte0)         acc_op = OP_CPPR;
            else if (acc_word) acc_op = OP_EOI;
         end else begin
            if (byte0)         acc_op = OP_POLL_B;
            else if (acc_word) acc_op = OP_ACCEPT;
         end
      end else if (idx == IDX_W'(IDX_PEND)) begin
         if (byte0) acc_op = acc_write ? OP_PEND_WR : OP_PEND_RD;
      end else if (link_hit) begin
         if (acc_word) acc_op = acc_write ? OP_LINK_WR : OP_LINK_RD;
      end
   end

endmodule

// File: rtl/icpf_links.sv
module icpf_links #(
   parameter int DATA_W    = 32,
   parameter int NUM_LINKS = 3,
   localparam int LSEL_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LSEL_W-1:0] sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_val
);

   logic [DATA_W-1:0] regs [NUM_LINKS];

   for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
      always_ff @(posedge clk) begin
         if (!rst_n)                                regs[g] <= '0;
         else if (wr_en && (sel == LSEL_W'(g)))     regs[g] <= wdata;
      end

      AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (sel == LSEL_W'(g))) |=> $stable(regs[g])); // R7
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_LINKS; i++)
         if (sel == LSEL_W'(i)) rd_val = regs[i];
   end

endmodule

// File: rtl/icpf_resp.sv
module icpf_resp
   import icpf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  op_e               rd_op,
   input  logic [DATA_W-1:0] poll_val,
   input  logic [DATA_W-1:0] accept_val,
   input  logic [PRIO_W-1:0] pend_val,
   input  logic [DATA_W-1:0] link_val,
   output logic [DATA_W-1:0] rdata
);

   localparam int PAD_W = DATA_W - PRIO_W;

   logic [DATA_W-1:0] nxt;

   always_comb begin
      unique case (rd_op)
         OP_POLL_W:  nxt = poll_val;
         OP_POLL_B:  nxt = {{PAD_W{1'b0}}, poll_val[DATA_W-1 -: PRIO_W]};
         OP_ACCEPT:  nxt = accept_val;
         OP_PEND_RD: nxt = {{PAD_W{1'b0}}, pend_val};
         OP_LINK_RD: nxt = link_val;
         default:    nxt = '1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= nxt;
   end

   AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_op == OP_BAD) |=> (rdata == '1)); // R9
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R5

endmodule

// File: rtl/icpf_top.sv
module icpf_top
   import icpf_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int PRIO_W    = 8,
   parameter int NUM_LINKS = 3,
   parameter int LINK_BASE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic              bus_word,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              err_flag,
   input  logic              err_clr,
   output logic              cmd_poll,
   output logic              cmd_accept,
   output logic              cmd_cppr,
   output logic              cmd_eoi,
   output logic              cmd_mfrr,
   output logic [DATA_W-1:0] cmd_data,
   input  logic [DATA_W-1:0] core_poll,
   input  logic [DATA_W-1:0] core_accept,
   input  logic [PRIO_W-1:0] core_mfrr
);

   localparam int LSEL_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;
   localparam int PAD_W  = DATA_W - PRIO_W;

   if (PRIO_W >= DATA_W) begin : g_bad_prio
      $error("PRIO_W must be narrower than DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W too small for the register window");
   end
   if (LINK_BASE <= IDX_PEND) begin : g_bad_base
      $error("link registers overlap the fixed registers");
   end

   op_e               op;
   logic [LSEL_W-1:0] link_sel;
   logic [DATA_W-1:0] link_val;

   icpf_decode #(
      .ADDR_W(ADDR_W), .NUM_LINKS(NUM_LINKS), .LINK_BASE(LINK_BASE)
   ) u_dec (
      .acc_write(bus_write),
      .acc_word (bus_word),
      .acc_addr (bus_addr),
      .acc_op   (op),
      .link_sel (link_sel)
   );

   icpf_links #(.DATA_W(DATA_W), .NUM_LINKS(NUM_LINKS)) u_links (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_valid && op == OP_LINK_WR),
      .sel   (link_sel),
      .wdata (bus_wdata),
      .rd_val(link_val)
   );

   icpf_resp #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (bus_valid && !bus_write),
      .rd_op     (op),
      .poll_val  (core_poll),
      .accept_val(core_accept),
      .pend_val  (core_mfrr),
      .link_val  (link_val),
      .rdata     (bus_rdata)
   );

   // command strobes: one per valid access
   assign cmd_poll   = bus_valid && (op == OP_POLL_W || op == OP_POLL_B);
   assign cmd_accept = bus_valid && (op == OP_ACCEPT);
   assign cmd_cppr   = bus_valid && (op == OP_CPPR);
   assign cmd_eoi    = bus_valid && (op == OP_EOI);
   assign cmd_mfrr   = bus_valid && (op == OP_PEND_WR);
   assign cmd_data   = bus_word ? bus_wdata : {{PAD_W{1'b0}}, bus_wdata[PRIO_W-1:0]};

   // sticky error: a new illegal access outranks the clear
   always_ff @(posedge clk) begin
      if (!rst_n)                         err_flag <= 1'b0;
      else if (bus_valid && op == OP_BAD) err_flag <= 1'b1;
      else if (err_clr)                   err_flag <= 1'b0;
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_poll, cmd_accept, cmd_cppr, cmd_eoi, cmd_mfrr})); // R9
   AST_ACCEPT_WORD_RD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_accept |-> (!bus_write && bus_word && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_REQ))); // R4
   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && op == OP_BAD) |=> err_flag); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag); // R10

endmodule

// File: tb/icpf_top_test.sv
module icpf_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        err_flag;
   logic        err_clr = 1'b0;
   logic        cmd_poll, cmd_accept, cmd_cppr, cmd_eoi, cmd_mfrr;
   logic [31:0] cmd_data;
   logic [31:0] core_poll, core_accept;
   logic [7:0]  core_mfrr;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   icpf_top uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .err_flag(err_flag), .err_clr(err_clr),
      .cmd_poll(cmd_poll), .cmd_accept(cmd_accept), .cmd_cppr(cmd_cppr),
      .cmd_eoi(cmd_eoi), .cmd_mfrr(cmd_mfrr), .cmd_data(cmd_data),
      .core_poll(core_poll), .core_accept(core_accept), .core_mfrr(core_mfrr)
   );

   // stub presenter core
   logic [7:0]  s_cppr;
   logic [7:0]  s_pend;
   logic [23:0] s_cnt;
   logic [31:0] s_eoi;
   assign core_poll   = {s_cppr, 24'h000A11};
   assign core_accept = {s_cppr, s_cnt};
   assign core_mfrr   = s_pend;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_cppr <= 8'h5A; s_pend <= 8'hFF; s_cnt <= 24'h000100; s_eoi <= '0;
      end else begin
         if (cmd_accept) s_cnt  <= s_cnt + 24'd1;
         if (cmd_cppr)   s_cppr <= cmd_data[7:0];
         if (cmd_mfrr)   s_pend <= cmd_data[7:0];
         if (cmd_eoi)    s_eoi  <= cmd_data;
      end
   end

   logic [4:0]  st;     // {poll, accept, cppr, eoi, mfrr} seen during the access
   logic [31:0] cd;     // command data seen during the access

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one access; on return read data of that access is visible
   task automatic acc(input logic wr, input logic wd, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_word = wd; bus_addr = a; bus_wdata = d;
      #1;
      st = {cmd_poll, cmd_accept, cmd_cppr, cmd_eoi, cmd_mfrr};
      cd = cmd_data;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      #1;
      if ({cmd_poll, cmd_accept, cmd_cppr, cmd_eoi, cmd_mfrr} != 5'b0) st = 5'b11111;
   endtask

   task automatic clear_err;
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 rdata", bus_rdata, 32'h0);
      chk("R1 err", {31'b0, err_flag}, 32'h0);
      for (int i = 0; i < 3; i++) begin
         acc(1'b0, 1'b1, 12'(16 + 4 * i), '0);
         chk("R1 link", bus_rdata, 32'h0);
      end
   endtask

   task automatic t_poll;
      acc(1'b0, 1'b1, 12'h000, '0);
      chk("R2 strobe", {27'b0, st}, 32'b10000);
      chk("R2 data", bus_rdata, 32'h5A000A11);
      chk("R2 no accept", {8'b0, s_cnt}, 32'h100);
      acc(1'b0, 1'b0, 12'h000, '0);
      chk("R3 strobe off0", {27'b0, st}, 32'b10000);
      chk("R3 data off0", bus_rdata, 32'h0000005A);
      acc(1'b0, 1'b0, 12'h004, '0);
      chk("R3 strobe off4", {27'b0, st}, 32'b10000);
      chk("R3 data off4", bus_rdata, 32'h0000005A);
      chk("R3 no accept", {8'b0, s_cnt}, 32'h100);
   endtask

   task automatic t_accept;
      acc(1'b0, 1'b1, 12'h004, '0);
      chk("R4 strobe", {27'b0, st}, 32'b01000);
      chk("R4 data", bus_rdata, 32'h5A000100);
      acc(1'b0, 1'b1, 12'h004, '0);
      chk("R4 data 2nd", bus_rdata, 32'h5A000101);
      chk("R4 count", {8'b0, s_cnt}, 32'h102);
   endtask

   task automatic t_cppr_eoi;
      acc(1'b1, 1'b0, 12'h004, 32'hFFFFFF33);
      chk("R5 cppr strobe", {27'b0, st}, 32'b00100);
      chk("R5 cppr data", cd, 32'h00000033);
      acc(1'b0, 1'b1, 12'h000, '0);
      chk("R5 cppr applied", bus_rdata, 32'h33000A11);
      acc(1'b1, 1'b1, 12'h004, 32'hDEADBEEF);
      chk("R5 eoi strobe", {27'b0, st}, 32'b00010);
      chk("R5 eoi data", s_eoi, 32'hDEADBEEF);
      chk("R5 rdata held", bus_rdata, 32'h33000A11);
   endtask

   task automatic t_pend;
      acc(1'b1, 1'b0, 12'h00C, 32'h00000007);
      chk("R6 wr strobe", {27'b0, st}, 32'b00001);
      acc(1'b0, 1'b0, 12'h00C, '0);
      chk("R6 rd data", bus_rdata, 32'h00000007);
      chk("R6 err clear", {31'b0, err_flag}, 32'h0);
      acc(1'b0, 1'b1, 12'h00C, '0);
      chk("R6 word rd", bus_rdata, 32'hFFFFFFFF);
      chk("R6 word err", {31'b0, err_flag}, 32'h1);
      acc(1'b1, 1'b1, 12'h00C, 32'h00000002);
      chk("R6 word wr strobe", {27'b0, st}, 32'b0);
      acc(1'b0, 1'b0, 12'h00C, '0);
      chk("R6 word wr ignored", bus_rdata, 32'h00000007);
   endtask

   task automatic t_err;
      clear_err;
      chk("R10 clear", {31'b0, err_flag}, 32'h0);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_word = 1'b1; bus_addr = 12'h008; err_clr = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0; err_clr = 1'b0;
      chk("R10 set wins", {31'b0, err_flag}, 32'h1);
      @(negedge clk); @(negedge clk);
      chk("R10 sticky", {31'b0, err_flag}, 32'h1);
      clear_err;
      chk("R10 cleared", {31'b0, err_flag}, 32'h0);
   endtask

   task automatic t_links;
      acc(1'b1, 1'b1, 12'h010, 32'h11111111);
      acc(1'b1, 1'b1, 12'h014, 32'h22222222);
      acc(1'b1, 1'b1, 12'h018, 32'h33333333);
      acc(1'b0, 1'b1, 12'h010, '0); chk("R7 link0", bus_rdata, 32'h11111111);
      acc(1'b0, 1'b1, 12'h014, '0); chk("R7 link1", bus_rdata, 32'h22222222);
      acc(1'b0, 1'b1, 12'h018, '0); chk("R7 link2", bus_rdata, 32'h33333333);
      chk("R7 no err", {31'b0, err_flag}, 32'h0);
      acc(1'b1, 1'b0, 12'h010, 32'h000000AA);
      chk("R7 byte err", {31'b0, err_flag}, 32'h1);
      acc(1'b0, 1'b1, 12'h010, '0); chk("R7 byte ignored", bus_rdata, 32'h11111111);
      acc(1'b0, 1'b0, 12'h014, '0); chk("R7 byte rd", bus_rdata, 32'hFFFFFFFF);
      clear_err;
   endtask

   task automatic t_misaligned;
      acc(1'b0, 1'b0, 12'h001, '0);
      chk("R8 off0 lane1", bus_rdata, 32'hFFFFFFFF);
      chk("R8 no strobe", {27'b0, st}, 32'b0);
      chk("R8 err", {31'b0, err_flag}, 32'h1);
      acc(1'b1, 1'b0, 12'h006, 32'h00000011);
      chk("R8 wr no strobe", {27'b0, st}, 32'b0);
      acc(1'b0, 1'b0, 12'h00D, '0);
      chk("R8 off12 lane1", bus_rdata, 32'hFFFFFFFF);
      acc(1'b0, 1'b1, 12'h000, '0);
      chk("R8 cppr unchanged", bus_rdata, 32'h33000A11);
      clear_err;
   endtask

   task automatic t_illegal;
      acc(1'b0, 1'b1, 12'h01C, '0);
      chk("R9 off28", bus_rdata, 32'hFFFFFFFF);
      chk("R9 err", {31'b0, err_flag}, 32'h1);
      acc(1'b0, 1'b1, 12'hFFC, '0);
      chk("R9 offFFC", bus_rdata, 32'hFFFFFFFF);
      chk("R9 no strobe", {27'b0, st}, 32'b0);
      acc(1'b1, 1'b1, 12'h000, 32'h12345678);
      chk("R9 wr off0 strobe", {27'b0, st}, 32'b0);
      acc(1'b1, 1'b1, 12'h008, 32'h12345678);
      chk("R9 wr off8 strobe", {27'b0, st}, 32'b0);
      chk("R9 eoi unchanged", s_eoi, 32'hDEADBEEF);
      clear_err;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_poll;
      t_accept;
      t_cppr_eoi;
      t_pend;
      t_err;
      t_links;
      t_misaligned;
      t_illegal;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule